// File: doc/BRIEF.md
# Command Descriptor Register Loader

This block lets a DMA channel reprogram its own registers from a command descriptor held in memory. A descriptor is a stream of 32-bit words. The first word is a header bitmask, and the words after it are payload. Each set header bit that names a channel register takes exactly one payload word. Payload words carry no gaps and no addresses of their own. The register that a payload word lands in depends only on how many loadable header bits are set below the bit it belongs to.

The loader takes the descriptor on a valid/ready word stream. It turns each payload word into a write on a plain address/data register-write port, in ascending header bit order. It can also issue a one-cycle clear of the loadable registers before any payload write. When the last set bit has been used, it pulses a load-complete strobe, which tells the channel it may start. The link-address word is written like any other register. Its bit 0 is the chain-continue flag, and the loader passes it through unchanged for the channel to act on.

A load begins with a one-cycle start pulse. The loader accepts words only while a load is in progress.

Top module: `cmd_hdr_loader`

## Requirements
- R1: After reset, and whenever no load is in progress, `word_ready_o`, `wr_en_o`, `regs_clear_o` and `load_done_o` are all low.
- R2: Header bits map to these register offsets:
  - bit 2 → 0x08
  - bit 3 → 0x0C
  - bits 4 and 5 → 0x10 and 0x14
  - bits 6 and 7 → 0x18 and 0x1C
  - bits 8 and 9 → 0x20 and 0x24
  - bits 10 and 11 → 0x28 and 0x2C
  - bit 12 → 0x30
  - bit 14 → 0x38
  - bits 19 and 20 → 0x4C and 0x50
  - bits 29, 30 and 31 → 0x74, 0x78 and 0x7C

  Successive payload words are written to the offsets of the set bits, taken from the lowest bit to the highest.
- R3: A load consumes exactly one payload word per set loadable header bit. `load_done_o` pulses for one cycle, in the same cycle as the last write, and `word_ready_o` is low in the following cycle.
- R4: Header bit 0 (register clear) produces a one-cycle `regs_clear_o` pulse in the cycle after the header is accepted. That pulse comes before the first write, and bit 0 consumes no payload word.
- R5: A header with no loadable bit set produces no writes, and `load_done_o` pulses in the cycle after the header is accepted.
- R6: Header bits 1, 13, 15 to 18 and 21 to 28 are reserved. They are ignored and consume no payload word.
- R7: Each write appears one cycle after its payload word is accepted, with the word's data unchanged. No write occurs while `word_valid_i` is low.
- R8: A start pulse that arrives while a load is in progress is ignored. It neither restarts nor extends the load.
- R9: The link-address word, including its bit 0 chain flag, is written verbatim. This covers a copy descriptor of 11 payload words and a fill descriptor of 9 payload words that ends in a zero link address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to fetch a descriptor |
| word_valid_i | input | 1 | Descriptor word available |
| word_data_i | input | WORD_W | Descriptor word (header first, then payload) |
| word_ready_o | output | 1 | Loader accepts a word this cycle; high exactly while a load is in progress |
| regs_clear_o | output | 1 | One-cycle clear of all loadable registers |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | ADDR_W | Register offset within the channel |
| wr_data_o | output | WORD_W | Register write data |
| load_done_o | output | 1 | One-cycle pulse: descriptor fully applied, channel may start |

## Verification
The bench goes after the following corner cases:
- Headers where reserved bits sit between loadable ones. A loader that counts reserved bits would stall waiting for words that never come, or would shift every later word to the wrong offset.
- The clear bit on its own and together with payload. A design that spends a word on the clear, or that clears after a write, shows up as a hang or as an early write.
- Empty headers, to expose a missing or late completion pulse.
- The full 17-word header and random headers, fed with random valid gaps and with a stray start pulse in the middle of a load. These catch writes that skip a bit, reorder the bits, or restart the load.

// File: rtl/cmdl_pkg.sv
package cmdl_pkg;

    localparam int HDR_BITS  = 32;
    localparam int CLEAR_BIT = 0;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HDR  = 2'd1,
        S_PAY  = 2'd2
    } ld_state_e;

    // Register offset for a header bit; zero means the bit loads nothing.
    function automatic logic [7:0] slot_offset(input int b);
        case (b)
            2:  return 8'h08;
            3:  return 8'h0C;
            4:  return 8'h10;
            5:  return 8'h14;
            6:  return 8'h18;
            7:  return 8'h1C;
            8:  return 8'h20;
            9:  return 8'h24;
            10: return 8'h28;
            11: return 8'h2C;
            12: return 8'h30;
            14: return 8'h38;
            19: return 8'h4C;
            20: return 8'h50;
            29: return 8'h74;
            30: return 8'h78;
            31: return 8'h7C;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [HDR_BITS-1:0] loadable_mask();
        logic [HDR_BITS-1:0] m;
        m = '0;
        for (int i = 0; i < HDR_BITS; i++) begin
            m[i] = (slot_offset(i) != 8'h00);
        end
        return m;
    endfunction

endpackage

// File: rtl/cmdl_lowbit.sv
module cmdl_lowbit #(
    parameter int N = 32
) (
    input  logic [N-1:0] vec_i,
    output logic [N-1:0] onehot_o
);
    // Isolate the lowest set bit: each bit survives only if nothing below is set.
    logic [N:0] below;
    assign below[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_scan
        assign onehot_o[i]  = vec_i[i] & ~below[i];
        assign below[i+1]   = below[i] | vec_i[i];
    end
endmodule

// File: rtl/cmdl_addr_map.sv
module cmdl_addr_map
    import cmdl_pkg::*;
#(
    parameter int N      = HDR_BITS,
    parameter int ADDR_W = 8
) (
    input  logic [N-1:0]      onehot_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] term [N];

    for (genvar i = 0; i < N; i++) begin : g_slot
        localparam logic [ADDR_W-1:0] OFF = ADDR_W'(slot_offset(i));
        assign term[i] = onehot_i[i] ? OFF : '0;
    end

    always_comb begin
        addr_o = '0;
        for (int i = 0; i < N; i++) begin
            addr_o = addr_o | term[i];
        end
    end
endmodule

// File: rtl/cmdl_seq.sv
module cmdl_seq
    import cmdl_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                word_valid_i,
    input  logic [WORD_W-1:0]   word_data_i,
    input  logic [HDR_BITS-1:0] pick_i,
    input  logic [ADDR_W-1:0]   pick_addr_i,
    output logic [HDR_BITS-1:0] pend_o,
    output logic                word_ready_o,
    output logic                regs_clear_o,
    output logic                wr_en_o,
    output logic [ADDR_W-1:0]   wr_addr_o,
    output logic [WORD_W-1:0]   wr_data_o,
    output logic                load_done_o
);
    localparam logic [HDR_BITS-1:0] LMASK = loadable_mask();

    ld_state_e           state;
    logic [HDR_BITS-1:0] pend;
    logic [HDR_BITS-1:0] hdr_bits;
    logic [HDR_BITS-1:0] pend_next;
    logic                accept;

    assign hdr_bits     = word_data_i[HDR_BITS-1:0] & LMASK;
    assign pend_next    = pend & ~pick_i;
    assign word_ready_o = (state != S_IDLE);
    assign accept       = word_ready_o && word_valid_i;
    assign pend_o       = pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= S_IDLE;
            pend         <= '0;
            regs_clear_o <= 1'b0;
            wr_en_o      <= 1'b0;
            wr_addr_o    <= '0;
            wr_data_o    <= '0;
            load_done_o  <= 1'b0;
        end else begin
            regs_clear_o <= 1'b0;
            wr_en_o      <= 1'b0;
            load_done_o  <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start_i) state <= S_HDR;
                end
                S_HDR: begin
                    if (accept) begin
                        pend         <= hdr_bits;
                        regs_clear_o <= word_data_i[CLEAR_BIT];
                        if (hdr_bits == '0) begin
                            load_done_o <= 1'b1;
                            state       <= S_IDLE;
                        end else begin
                            state <= S_PAY;
                        end
                    end
                end
                S_PAY: begin
                    if (accept) begin
                        wr_en_o   <= 1'b1;
                        wr_addr_o <= pick_addr_i;
                        wr_data_o <= word_data_i;
                        pend      <= pend_next;
                        if (pend_next == '0) begin
                            load_done_o <= 1'b1;
                            state       <= S_IDLE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R2: the pending set only ever loses bits during payload
    p_pend_shrinks_r2: assert property (@(posedge clk) disable iff (rst)
        (state == S_PAY) |=> ((pend & ~$past(pend)) == '0));

    // R3: every accepted payload word retires exactly one header bit
    p_one_bit_per_word_r3: assert property (@(posedge clk) disable iff (rst)
        (state == S_PAY && word_valid_i) |=> ($countones($past(pend) & ~pend) == 1));

    // R6: no reserved bit ever becomes pending
    p_no_reserved_pending_r6: assert property (@(posedge clk) disable iff (rst)
        (pend & ~LMASK) == '0);
endmodule

// File: rtl/cmd_hdr_loader.sv
module cmd_hdr_loader
    import cmdl_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_data_i,
    output logic              word_ready_o,
    output logic              regs_clear_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [WORD_W-1:0] wr_data_o,
    output logic              load_done_o
);
    logic [HDR_BITS-1:0] pend;
    logic [HDR_BITS-1:0] pick;
    logic [ADDR_W-1:0]   pick_addr;

    cmdl_lowbit #(.N(HDR_BITS)) u_pick (
        .vec_i    (pend),
        .onehot_o (pick)
    );

    cmdl_addr_map #(.N(HDR_BITS), .ADDR_W(ADDR_W)) u_map (
        .onehot_i (pick),
        .addr_o   (pick_addr)
    );

    cmdl_seq #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .word_valid_i (word_valid_i),
        .word_data_i  (word_data_i),
        .pick_i       (pick),
        .pick_addr_i  (pick_addr),
        .pend_o       (pend),
        .word_ready_o (word_ready_o),
        .regs_clear_o (regs_clear_o),
        .wr_en_o      (wr_en_o),
        .wr_addr_o    (wr_addr_o),
        .wr_data_o    (wr_data_o),
        .load_done_o  (load_done_o)
    );

    // R7: a write only follows an accepted word
    p_write_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> $past(word_valid_i && word_ready_o));

    // R3: completion is a single-cycle pulse
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        load_done_o |=> !load_done_o);

    // R4: the clear never shares a cycle with a register write
    p_clear_alone_r4: assert property (@(posedge clk) disable iff (rst)
        regs_clear_o |-> !wr_en_o);

    // R1: nothing is accepted while idle, so no write may follow an idle cycle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !word_ready_o |=> !wr_en_o);
endmodule

// File: tb/cmd_hdr_loader_test.sv
module cmd_hdr_loader_test;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 8;
    localparam logic [31:0] LOADABLE = 32'hE018_5FFC;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic              word_valid_i = 1'b0;
    logic [WORD_W-1:0] word_data_i = '0;
    logic              word_ready_o, regs_clear_o, wr_en_o, load_done_o;
    logic [ADDR_W-1:0] wr_addr_o;
    logic [WORD_W-1:0] wr_data_o;

    int total = 0;
    int fails = 0;

    logic [ADDR_W-1:0] got_a[$];
    logic [WORD_W-1:0] got_d[$];
    int done_cnt, done_with_wr, clr_cnt;
    bit clr_late;

    always #5 clk = ~clk;

    cmd_hdr_loader #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .word_valid_i(word_valid_i), .word_data_i(word_data_i),
        .word_ready_o(word_ready_o), .regs_clear_o(regs_clear_o),
        .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .load_done_o(load_done_o)
    );

    function automatic logic [7:0] exp_off(input int b);
        case (b)
            2: return 8'h08;  3: return 8'h0C;  4: return 8'h10;  5: return 8'h14;
            6: return 8'h18;  7: return 8'h1C;  8: return 8'h20;  9: return 8'h24;
            10: return 8'h28; 11: return 8'h2C; 12: return 8'h30; 14: return 8'h38;
            19: return 8'h4C; 20: return 8'h50; 29: return 8'h74; 30: return 8'h78;
            31: return 8'h7C;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en_o) begin
                got_a.push_back(wr_addr_o);
                got_d.push_back(wr_data_o);
                if (load_done_o) done_with_wr++;
            end
            if (regs_clear_o) begin
                clr_cnt++;
                if (got_a.size() != 0) clr_late = 1'b1;
            end
            if (load_done_o) done_cnt++;
        end
    end

    // last_mode: 0 random payload, 1 final word forced to 0, 2 final word bit0 set
    task automatic run_desc(input logic [31:0] hdr, input int last_mode,
                            input bit poke, input string tag);
        logic [31:0] words[$];
        logic [ADDR_W-1:0] ea[$];
        logic [WORD_W-1:0] ed[$];
        int n, idx, k;
        bit addr_ok, data_ok;
        n = $countones(hdr & LOADABLE);
        words.push_back(hdr);
        for (int i = 0; i < n; i++) words.push_back($urandom);
        if (n > 0 && last_mode == 1) words[n] = 32'h0;
        if (n > 0 && last_mode == 2) words[n] = words[n] | 32'h1;
        k = 1;
        for (int b = 0; b < 32; b++) begin
            if (hdr[b] && LOADABLE[b]) begin
                ea.push_back(exp_off(b));
                ed.push_back(words[k]);
                k++;
            end
        end
        @(negedge clk);
        got_a.delete(); got_d.delete();
        done_cnt = 0; done_with_wr = 0; clr_cnt = 0; clr_late = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        idx = 0;
        while (idx < n + 1) begin
            @(negedge clk);
            start_i = poke && (idx == 1);
            if ($urandom % 4 == 0) begin
                word_valid_i = 1'b0;
            end else begin
                word_valid_i = 1'b1;
                word_data_i  = words[idx];
                if (word_ready_o) idx++;
            end
        end
        @(negedge clk);
        word_valid_i = 1'b0;
        start_i = 1'b0;
        repeat (2) @(negedge clk);
        chk(got_a.size() == n, {tag, " R3/R6 write count"}, got_a.size(), n);
        addr_ok = (got_a.size() == n);
        data_ok = addr_ok;
        if (addr_ok) begin
            for (int i = 0; i < n; i++) begin
                if (got_a[i] != ea[i]) addr_ok = 0;
                if (got_d[i] != ed[i]) data_ok = 0;
            end
        end
        chk(addr_ok, {tag, " R2 offsets ascending"}, addr_ok, 1);
        chk(data_ok, {tag, " R7/R9 data verbatim"}, data_ok, 1);
        chk(done_cnt == 1, {tag, " R3 single done"}, done_cnt, 1);
        if (n > 0)
            chk(done_with_wr == 1, {tag, " R3 done with last write"}, done_with_wr, 1);
        else
            chk(done_with_wr == 0, {tag, " R5 empty header done"}, done_with_wr, 0);
        chk(clr_cnt == int'(hdr[0]), {tag, " R4 clear pulses"}, clr_cnt, hdr[0]);
        chk(!clr_late, {tag, " R4 clear before writes"}, clr_late, 0);
        chk(!word_ready_o, {tag, " R3/R8 idle after done"}, word_ready_o, 0);
        // Words offered while idle must not be consumed or written (R1)
        word_valid_i = 1'b1;
        word_data_i  = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        word_valid_i = 1'b0;
        chk(got_a.size() == n, {tag, " R1 no write while idle"}, got_a.size(), n);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!word_ready_o && !wr_en_o && !load_done_o && !regs_clear_o,
            "R1 reset state", {word_ready_o, wr_en_o, load_done_o, regs_clear_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!word_ready_o, "R1 idle after reset", word_ready_o, 0);

        run_desc(32'h0000_0000, 0, 0, "empty");
        run_desc(32'h0000_0001, 0, 0, "clear-only");
        run_desc(32'h1FE7_A002, 0, 0, "reserved-only");
        run_desc(32'h1FE7_A00B, 0, 0, "reserved-mixed R6");
        run_desc(32'h4000_1FF8, 2, 0, "copy R9");
        run_desc(32'h4000_5BC8, 1, 0, "fill R9");
        run_desc(32'hE018_5FFD, 0, 0, "all-bits");
        run_desc(32'h4000_1FF9, 0, 1, "start-poke R8");
        for (int t = 0; t < 24; t++) begin
            run_desc($urandom, 0, (t % 5 == 0), "random");
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule